// File: doc/BRIEF.md
# Shared Serial EEPROM Burst Reader

This block reads a run of 16-bit words from a three-wire serial EEPROM (chip select, serial clock, data in and data out). A one-cycle start pulse supplies a first word address and a word count. For each word the block runs one complete access: a read command made of a three-bit read opcode followed by the word address, one idle half period, and then sixteen data bits clocked in. Each word appears on the output with a one-cycle valid strobe. Consecutive words come from consecutive addresses.

Another agent may share the EEPROM. In shared mode the reader raises a request and waits a bounded time for a grant before it drives the serial lines. It holds the request for the whole burst and then gives up the part with a one-cycle done strobe. If no grant arrives in time, it pulses done, flags a timeout and makes no access. In unshared mode the arbitration step is skipped. An optional signature check treats the first word of a burst as a marker. If that word reads all zeros or all ones, the contents are flagged as blank and the burst stops.

Each serial half period lasts a parameterised number of system clocks. A typical use is to fetch a station address as three consecutive words after checking the signature word.

Top module: `eeprom_burst_reader`

## Requirements
- R1: After reset, ee_cs, ee_sk, ee_di, ee_req, ee_done, rd_valid, busy, timeout_err and blank_err are all low.
- R2: Every word access begins with ee_cs, ee_sk and ee_di low. ee_cs rises before the first ee_sk rising edge, and ee_sk is never high while ee_cs is low. The access ends by driving all three lines low together.
- R3: The command is ADDR_W+3 bits, shifted MSB first: the opcode 3'b110, then the word address. ee_di changes only while ee_sk is low and stays stable through each high half.
- R4: After the command, ee_cs is held high with ee_sk low for one half period. Then 16 serial clocks follow, and ee_do is sampled at the end of each high half, MSB first. The assembled word is driven on rd_word with rd_valid high for exactly one cycle.
- R5: Every high half of ee_sk lasts exactly HALF_CLKS system clocks.
- R6: A burst reads word_count words from start_addr, start_addr+1, and so on. Addresses wrap modulo 2^ADDR_W.
- R7: With shared_mode high, ee_req rises in the cycle after the start pulse and stays high until the burst ends. It then falls in the same cycle that ee_done pulses high for exactly one cycle.
- R8: ee_grant is sampled on each of the WAIT_UNITS*UNIT_CLKS clock edges that follow the start edge, and a grant seen on the last of them is still accepted. If none is seen, ee_req drops, ee_done pulses, timeout_err is set, and ee_cs never rises.
- R9: With shared_mode low, ee_req and ee_done stay low and the first access begins without waiting for ee_grant.
- R10: With sig_check high, a first word equal to 16'h0000 or 16'hFFFF sets blank_err. That word is still delivered, but no further word is read. A first word with any other value lets the burst continue normally.
- R11: A start pulse while busy is high is ignored. A word_count of zero performs no serial access, but still requests and releases the EEPROM in shared mode.
- R12: timeout_err and blank_err hold their value until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a burst |
| start_addr | input | ADDR_W | First word address |
| word_count | input | CNT_W | Number of words to read |
| shared_mode | input | 1 | 1: arbitrate with request/grant before reading |
| sig_check | input | 1 | 1: first word is a signature checked for blank contents |
| ee_grant | input | 1 | Grant from the other agent sharing the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_req | output | 1 | Request for the shared EEPROM |
| ee_done | output | 1 | One-cycle release strobe |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| rd_word | output | DATA_W | Last word read |
| rd_valid | output | 1 | One-cycle strobe for rd_word |
| busy | output | 1 | Burst in progress |
| timeout_err | output | 1 | Grant did not arrive in time |
| blank_err | output | 1 | Signature word was all zeros or all ones |

## Verification
The bench builds the reader with HALF_CLKS=2, WAIT_UNITS=5 and UNIT_CLKS=3. This gives a grant window of fifteen cycles, so the last-cycle grant and the first-too-late grant can both be hit exactly. A two-clock half period lets the EEPROM model measure every high half. ADDR_W=6 places the address wrap at word 63, where a short burst reaches it. CNT_W=3 keeps random bursts to seven words or fewer, so many bursts fit in the run and cover mixed shared, unshared, timed-out and signature cases.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
   typedef enum logic [1:0] {SQ_IDLE, SQ_ARB, SQ_READ} seq_st_t;
   typedef enum logic [1:0] {AB_IDLE, AB_WAIT, AB_HOLD} arb_st_t;
   localparam logic [2:0] RD_OPCODE = 3'b110;
endpackage

// File: rtl/eerd_word.sv
module eerd_word
   import eerd_pkg::*;
#(
   parameter int HALF_CLKS = 4,
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ee_do,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   output logic [DATA_W-1:0] data,
   output logic              fin
);
   localparam int CMD_W = ADDR_W + 3;
   localparam int NSTEP = 2*CMD_W + 2*DATA_W + 4;
   localparam int SW    = $clog2(NSTEP + 1);
   localparam int HW    = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
   localparam logic [SW-1:0] S_CMD0 = SW'(2);
   localparam logic [SW-1:0] S_GAP  = SW'(2 + 2*CMD_W);
   localparam logic [SW-1:0] S_DAT0 = SW'(3 + 2*CMD_W);
   localparam logic [SW-1:0] S_LAST = SW'(NSTEP - 1);

   if (HALF_CLKS < 1) begin : g_bad_half
      $error("eerd_word: HALF_CLKS must be at least 1");
   end

   logic              active;
   logic [SW-1:0]     stp;
   logic [CMD_W-1:0]  cmd;
   logic [DATA_W-1:0] shreg;
   logic              step_end;
   logic              in_cmd, in_data, sk_hi;

   // half-period divider: a single-clock step needs no counter
   if (HALF_CLKS == 1) begin : g_nodiv
      assign step_end = active;
   end else begin : g_div
      logic [HW-1:0] hcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 hcnt <= '0;
         else if (!active || step_end) hcnt <= '0;
         else                        hcnt <= hcnt + 1'b1;
      end
      assign step_end = active && (hcnt == HW'(HALF_CLKS - 1));
   end

   assign in_cmd  = (stp >= S_CMD0) && (stp < S_GAP);
   assign in_data = (stp >= S_DAT0) && (stp < S_LAST);
   // command steps start on an even index, data steps on an odd one
   assign sk_hi   = in_cmd ? stp[0] : (in_data ? ~stp[0] : 1'b0);

   assign ee_cs = active && (stp != '0) && (stp != S_LAST);
   assign ee_sk = active && sk_hi;
   assign ee_di = active && in_cmd && cmd[CMD_W-1];
   assign data  = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         stp    <= '0;
         cmd    <= '0;
         shreg  <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1;
               stp    <= '0;
               cmd    <= {RD_OPCODE, addr};
            end
         end else if (step_end) begin
            if (in_cmd && stp[0])   cmd   <= {cmd[CMD_W-2:0], 1'b0};
            if (in_data && !stp[0]) shreg <= {shreg[DATA_W-2:0], ee_do};
            if (stp == S_LAST) begin
               active <= 1'b0;
               fin    <= 1'b1;
            end else begin
               stp <= stp + 1'b1;
            end
         end
      end
   end

   p_sk_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> ee_cs);
   p_di_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
   p_frame_ends_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_cs) |-> (!ee_sk && !ee_di));
   p_fin_outside_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> !ee_cs);
endmodule

// File: rtl/eerd_arb.sv
module eerd_arb
   import eerd_pkg::*;
#(
   parameter int WAIT_CLKS = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   input  logic shared_i,
   input  logic grant_i,
   input  logic release_i,
   output logic req_o,
   output logic ok_o,
   output logic tout_o,
   output logic done_o
);
   localparam int WW = (WAIT_CLKS > 1) ? $clog2(WAIT_CLKS) : 1;

   if (WAIT_CLKS < 1) begin : g_bad_wait
      $error("eerd_arb: WAIT_CLKS must be at least 1");
   end

   arb_st_t       st;
   logic [WW-1:0] wcnt;
   logic          sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= AB_IDLE;
         wcnt   <= '0;
         sh_q   <= 1'b0;
         req_o  <= 1'b0;
         ok_o   <= 1'b0;
         tout_o <= 1'b0;
         done_o <= 1'b0;
      end else begin
         ok_o   <= 1'b0;
         tout_o <= 1'b0;
         done_o <= 1'b0;
         unique case (st)
            AB_IDLE: if (kick) begin
               sh_q <= shared_i;
               wcnt <= '0;
               if (shared_i) begin
                  req_o <= 1'b1;
                  st    <= AB_WAIT;
               end else begin
                  ok_o <= 1'b1;
                  st   <= AB_HOLD;
               end
            end
            AB_WAIT: if (grant_i) begin
               ok_o <= 1'b1;
               st   <= AB_HOLD;
            end else if (wcnt == WW'(WAIT_CLKS - 1)) begin
               tout_o <= 1'b1;
               done_o <= 1'b1;
               req_o  <= 1'b0;
               st     <= AB_IDLE;
            end else begin
               wcnt <= wcnt + 1'b1;
            end
            AB_HOLD: if (release_i) begin
               req_o  <= 1'b0;
               done_o <= sh_q;
               st     <= AB_IDLE;
            end
            default: st <= AB_IDLE;
         endcase
      end
   end

   p_tout_without_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tout_o |-> !$past(grant_i));
   p_req_only_shared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(shared_i));
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_req_falls_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_o) |-> done_o);
endmodule

// File: rtl/eeprom_burst_reader.sv
module eeprom_burst_reader
   import eerd_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 4,
   parameter int HALF_CLKS  = 4,
   parameter int WAIT_UNITS = 2000,
   parameter int UNIT_CLKS  = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  word_count,
   input  logic              shared_mode,
   input  logic              sig_check,
   input  logic              ee_grant,
   input  logic              ee_do,
   output logic              ee_req,
   output logic              ee_done,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   output logic [DATA_W-1:0] rd_word,
   output logic              rd_valid,
   output logic              busy,
   output logic              timeout_err,
   output logic              blank_err
);
   localparam int WAIT_CLKS = WAIT_UNITS * UNIT_CLKS;

   if (ADDR_W < 1 || DATA_W < 2 || CNT_W < 1) begin : g_bad_width
      $error("eeprom_burst_reader: widths out of range");
   end
   if (WAIT_UNITS < 1 || UNIT_CLKS < 1) begin : g_bad_timing
      $error("eeprom_burst_reader: wait timing out of range");
   end

   seq_st_t           st;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left;
   logic              first, go;
   logic              kick, rel;
   logic              a_ok, a_tout;
   logic              w_fin, w_blank, end_now;
   logic [DATA_W-1:0] w_data;

   assign kick    = start && (st == SQ_IDLE);
   assign busy    = (st != SQ_IDLE);
   assign w_blank = (w_data == '0) || (w_data == '1);
   assign end_now = (first && w_blank) || (left == CNT_W'(1));
   assign rel     = (st == SQ_ARB && !a_tout && a_ok && left == '0) ||
                    (st == SQ_READ && w_fin && end_now);

   eerd_arb #(.WAIT_CLKS(WAIT_CLKS)) u_arb (
      .clk(clk), .rst_n(rst_n), .kick(kick), .shared_i(shared_mode),
      .grant_i(ee_grant), .release_i(rel), .req_o(ee_req), .ok_o(a_ok),
      .tout_o(a_tout), .done_o(ee_done)
   );

   eerd_word #(.HALF_CLKS(HALF_CLKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_word (
      .clk(clk), .rst_n(rst_n), .go(go), .addr(addr_q), .ee_do(ee_do),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .data(w_data), .fin(w_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= SQ_IDLE;
         addr_q      <= '0;
         left        <= '0;
         first       <= 1'b0;
         go          <= 1'b0;
         rd_word     <= '0;
         rd_valid    <= 1'b0;
         timeout_err <= 1'b0;
         blank_err   <= 1'b0;
      end else begin
         go       <= 1'b0;
         rd_valid <= 1'b0;
         unique case (st)
            SQ_IDLE: if (start) begin
               addr_q      <= start_addr;
               left        <= word_count;
               first       <= sig_check;
               timeout_err <= 1'b0;
               blank_err   <= 1'b0;
               st          <= SQ_ARB;
            end
            SQ_ARB: if (a_tout) begin
               timeout_err <= 1'b1;
               st          <= SQ_IDLE;
            end else if (a_ok) begin
               if (left == '0) st <= SQ_IDLE;
               else begin
                  go <= 1'b1;
                  st <= SQ_READ;
               end
            end
            SQ_READ: if (w_fin) begin
               rd_word  <= w_data;
               rd_valid <= 1'b1;
               addr_q   <= addr_q + 1'b1;
               left     <= left - 1'b1;
               first    <= 1'b0;
               if (first && w_blank) blank_err <= 1'b1;
               if (end_now) st <= SQ_IDLE;
               else         go <= 1'b1;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   p_blank_ends_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blank_err) |-> !busy);
   p_timeout_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> !ee_cs);
   p_no_req_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ee_req);
endmodule

// File: tb/eeprom_burst_reader_test.sv
module eeprom_burst_reader_test;
   localparam int ADDR_W = 6, DATA_W = 16, CNT_W = 3;
   localparam int HALF = 2, UNITS = 5, UCLK = 3;
   localparam int WAIT_CLKS = UNITS * UCLK;
   localparam int CMD_W = ADDR_W + 3;
   localparam int DEPTH = 1 << ADDR_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, shared_mode = 1'b0, sig_check = 1'b0, ee_grant = 1'b0, ee_do = 1'b0;
   logic [ADDR_W-1:0] start_addr = '0;
   logic [CNT_W-1:0]  word_count = '0;
   logic ee_req, ee_done, ee_cs, ee_sk, ee_di, rd_valid, busy, timeout_err, blank_err;
   logic [DATA_W-1:0] rd_word;

   eeprom_burst_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .HALF_CLKS(HALF), .WAIT_UNITS(UNITS), .UNIT_CLKS(UCLK)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .shared_mode(shared_mode), .sig_check(sig_check),
      .ee_grant(ee_grant), .ee_do(ee_do), .ee_req(ee_req), .ee_done(ee_done),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .rd_word(rd_word),
      .rd_valid(rd_valid), .busy(busy), .timeout_err(timeout_err), .blank_err(blank_err));

   always #4 clk = ~clk;

   int n_chk = 0, n_err = 0;
   logic [15:0] mem [DEPTH];
   logic [15:0] rx_w [4096];
   int rx_n = 0, done_n = 0, cs_rises = 0;
   int v_frame = 0, v_cmd = 0, v_half = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit blank16(input logic [15:0] w);
      return (w == 16'h0000) || (w == 16'hFFFF);
   endfunction

   // EEPROM model and output monitor, sampled on the falling clock edge
   initial begin
      logic p_cs = 0, p_sk = 0, p_di = 0;
      int bitn = 0, hlen = 0;
      logic [CMD_W-1:0] cmd = '0;
      logic [15:0] mword = '0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            p_cs = 0; p_sk = 0; p_di = 0; bitn = 0; hlen = 0; ee_do = 0;
         end else begin
            if (rd_valid) begin rx_w[rx_n] = rd_word; rx_n++; end
            if (ee_done) done_n++;
            if (ee_cs && !p_cs) begin
               cs_rises++; bitn = 0; cmd = '0;
               if (p_sk || p_di || ee_sk) v_frame++;
            end
            if (!ee_cs && p_cs && (ee_sk || ee_di)) v_frame++;
            if (ee_sk && !ee_cs) v_frame++;
            if (ee_sk && p_sk && (ee_di != p_di)) v_cmd++;
            if (ee_sk) hlen = p_sk ? hlen + 1 : 1;
            else if (p_sk) begin
               if (hlen != HALF) v_half++;
               hlen = 0;
            end
            if (ee_sk && !p_sk && ee_cs) begin
               if (bitn < CMD_W) begin
                  cmd = {cmd[CMD_W-2:0], ee_di};
                  bitn++;
                  if (bitn == CMD_W) begin
                     if (cmd[CMD_W-1 -: 3] != 3'b110) v_cmd++;
                     mword = (cmd[CMD_W-1 -: 3] == 3'b110) ? mem[cmd[ADDR_W-1:0]]
                                                          : ~mem[cmd[ADDR_W-1:0]];
                  end
               end else if (bitn < CMD_W + 16) begin
                  ee_do = mword[15 - (bitn - CMD_W)];
                  bitn++;
               end
            end
            if (!ee_cs) ee_do = 0;
            p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
         end
      end
   end

   task automatic burst(input int a, input int n, input bit sh, input bit sg, input int gd,
                        input string tag);
      int exp_n = 0, lim = 0;
      bit exp_to = 0, exp_bl = 0;
      int rx0 = rx_n, dn0 = done_n, cs0 = cs_rises;
      int f0 = v_frame, c0 = v_cmd, h0 = v_half;
      exp_to = sh && (gd >= WAIT_CLKS);
      if (!exp_to && n > 0) begin
         if (sg && blank16(mem[a % DEPTH])) begin exp_n = 1; exp_bl = 1; end
         else exp_n = n;
      end
      @(negedge clk);
      start_addr = ADDR_W'(a); word_count = CNT_W'(n);
      shared_mode = sh; sig_check = sg; start = 1;
      @(negedge clk);
      start = 0;
      chk(busy == 1, {"R11 busy after start ", tag}, busy, 1);
      if (sh) chk(ee_req == 1, {"R7 req raised ", tag}, ee_req, 1);
      else    chk(ee_req == 0, {"R9 no req ", tag}, ee_req, 0);
      if (sh) begin
         repeat (gd) @(negedge clk);
         ee_grant = 1;
      end
      while (busy && lim < 20000) begin @(negedge clk); lim++; end
      @(negedge clk);
      @(negedge clk);
      ee_grant = 0;
      chk(rx_n - rx0 == exp_n, {"R6 word count ", tag}, rx_n - rx0, exp_n);
      for (int i = 0; i < exp_n && i < rx_n - rx0; i++)
         chk(rx_w[rx0+i] == mem[(a+i) % DEPTH], {"R4 word data ", tag},
             rx_w[rx0+i], mem[(a+i) % DEPTH]);
      chk(timeout_err == exp_to, {"R8 timeout flag ", tag}, timeout_err, exp_to);
      chk(blank_err == exp_bl, {"R10 blank flag ", tag}, blank_err, exp_bl);
      chk(done_n - dn0 == (sh ? 1 : 0), {"R7 done pulses ", tag}, done_n - dn0, sh);
      chk(ee_req == 0, {"R7 req released ", tag}, ee_req, 0);
      chk(cs_rises - cs0 == exp_n, {"R11 access count ", tag}, cs_rises - cs0, exp_n);
      chk(v_frame == f0, {"R2 framing ", tag}, v_frame - f0, 0);
      chk(v_cmd == c0, {"R3 command ", tag}, v_cmd - c0, 0);
      chk(v_half == h0, {"R5 half period ", tag}, v_half - h0, 0);
   endtask

   task automatic finish_up;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = 16'((i * 40503 + 12345) ^ (i << 9));
         if (blank16(mem[i])) mem[i] = 16'h1234;
      end
      mem[10] = 16'hFFFF;
      mem[20] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!ee_cs && !ee_sk && !ee_di, "R1 serial lines low", {ee_cs, ee_sk, ee_di}, 0);
      chk(!ee_req && !ee_done, "R1 arbitration idle", {ee_req, ee_done}, 0);
      chk(!busy && !rd_valid, "R1 not busy", {busy, rd_valid}, 0);
      chk(!timeout_err && !blank_err, "R1 flags clear", {timeout_err, blank_err}, 0);

      burst(0, 3, 0, 0, 0, "R9 unshared station address");
      burst(62, 4, 1, 0, 0, "R6 wrap");
      burst(7, 2, 1, 0, WAIT_CLKS - 1, "R8 last-cycle grant");
      burst(7, 2, 1, 0, WAIT_CLKS, "R8 late grant");
      repeat (5) @(negedge clk);
      chk(timeout_err == 1, "R12 timeout held", timeout_err, 1);
      burst(30, 1, 0, 0, 0, "R12 cleared by start");
      burst(10, 3, 1, 1, 2, "R10 all ones");
      repeat (5) @(negedge clk);
      chk(blank_err == 1, "R12 blank held", blank_err, 1);
      burst(20, 3, 0, 1, 0, "R10 all zeros");
      burst(11, 3, 1, 1, 1, "R10 good signature");
      burst(4, 0, 1, 0, 3, "R11 zero count shared");
      burst(4, 0, 0, 0, 0, "R11 zero count unshared");
      fork
         burst(5, 3, 0, 0, 0, "R11 start while busy");
         begin
            repeat (30) @(negedge clk);
            start_addr = ADDR_W'(40); start = 1;
            @(negedge clk);
            start = 0;
         end
      join
      chk(busy == 0, "R11 ignored start left idle", busy, 0);

      for (int k = 0; k < 30; k++) begin
         int a, n, gd;
         bit sh, sg;
         a  = int'($urandom % DEPTH);
         n  = int'($urandom % 8);
         sh = 1'($urandom % 2);
         sg = ($urandom % 4) == 0;
         gd = int'($urandom % (WAIT_CLKS + 4));
         burst(a, n, sh, sg, gd, "random");
      end
      finish_up();
   end
endmodule